// File: doc/BRIEF.md
# Crosspoint Switch Configuration Register

This block is the digital control side of an eight-output switch matrix. A 40-bit staging register holds one 5-bit slot per output. Each slot carries a 3-bit input select, a reserved bit and an enable. Software or a controller fills the staging register in one of two ways. In serial mode it shifts in one bit per clock from a data pin. In parallel mode it writes a 4-bit word into the slot picked by a 3-bit address.

The outputs of the matrix are driven by a second rank. The second rank takes a copy of the staging register on clock edges while the update strobe is held low. It is cleared at once by an active-low asynchronous reset. The most significant staging bit is always visible on a serial data-out pin, so several blocks can be chained or the register read back. A low chip enable is needed for any clock edge to take effect.

Top module: `xbar_cfg_ctrl`

## Requirements
- R1: Slot k occupies staging bits [5k+4:5k]. Inside a slot, bits [2:0] are the input select, bit 3 is reserved and bit 4 is the enable. The second rank presents slot k as out_en[k] and out_sel[3k+2:3k].
- R2: While ce_n is high, clock edges leave the staging register, sdo, out_en and out_sel unchanged, whatever the other inputs are.
- R3: An edge with ce_n low, upd_n high and par_sel low shifts the staging register one place toward its MSB, and sdi enters bit 0. A bit taken in on one edge is shown on sdo right after the 40th such edge, counting that edge as the first.
- R4: An edge with ce_n low, upd_n high and par_sel high writes slot paddr. The slot gets enable = pdata[3], reserved = 1 and select = pdata[2:0]. All other slots keep their value.
- R5: sdo always equals staging bit 39, the enable of output 7, in both serial and parallel mode.
- R6: An edge with ce_n low and upd_n low copies the enable and select fields of every slot into the second rank, and the staging register does not move on that edge. With upd_n high or ce_n high, the second rank holds its value.
- R7: Driving rst_n low clears every out_en and out_sel bit at once, with no clock edge needed. The staging register keeps its contents, so a later update restores the configuration that was staged.
- R8: Any slot written in parallel mode reads back its reserved bit as 1 when the staging register is shifted out on sdo.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the staging register and the second rank |
| rst_n | input | 1 | Asynchronous active-low clear of the second rank |
| ce_n | input | 1 | Active-low enable; when high, all edges are ignored |
| par_sel | input | 1 | 1 = addressed parallel write, 0 = serial shift |
| upd_n | input | 1 | Active-low update strobe that copies staging into the second rank |
| sdi | input | 1 | Serial data in, enters staging bit 0 |
| pdata | input | 4 | Parallel word: bit 3 is the enable, bits 2:0 are the select |
| paddr | input | 3 | Slot address used for a parallel write |
| sdo | output | 1 | Staging register MSB |
| out_en | output | 8 | Per-output enable from the second rank |
| out_sel | output | 24 | Per-output 3-bit input select from the second rank |

## Verification
If a staging bit is corrupted, the fault is invisible at the matrix outputs until the next update edge. It does show on sdo within at most 40 serial shifts, so the bench shifts whole images out and compares every bit, reserved bits included. If the second rank is wrong, the fault shows on out_en and out_sel on the very edge that loads it. An update that also moved the staging register would show on the following update or readback. Reset clearing is checked between clock edges, and the bench checks that the staged image survives reset.

// File: rtl/xbar_cfg_pkg.sv
package xbar_cfg_pkg;

    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_SHIFT  = 2'd1,
        OP_WRITE  = 2'd2,
        OP_UPDATE = 2'd3
    } cfg_op_e;

    // Chip enable dominates; an update edge neither shifts nor writes.
    function automatic cfg_op_e op_decode(input logic ce_n,
                                          input logic par_sel,
                                          input logic upd_n);
        if (ce_n)    return OP_IDLE;
        if (!upd_n)  return OP_UPDATE;
        if (par_sel) return OP_WRITE;
        return OP_SHIFT;
    endfunction

endpackage

// File: rtl/xbar_slot_dec.sv
module xbar_slot_dec #(
    parameter int NUM_OUT = 8,
    parameter int ADDR_W  = $clog2(NUM_OUT)
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               en,
    output logic [NUM_OUT-1:0] hit
);
    for (genvar k = 0; k < NUM_OUT; k++) begin : g_hit
        assign hit[k] = en && (addr == ADDR_W'(k));
    end
endmodule

// File: rtl/xbar_cfg_shreg.sv
module xbar_cfg_shreg
    import xbar_cfg_pkg::*;
#(
    parameter int NUM_OUT = 8,
    parameter int SEL_W   = 3,
    parameter int SLOT_W  = SEL_W + 2,
    parameter int REG_W   = NUM_OUT * SLOT_W
) (
    input  logic               clk,
    input  cfg_op_e            op,
    input  logic               sdi,
    input  logic [SEL_W:0]     pdata,
    input  logic [NUM_OUT-1:0] hit,
    output logic [REG_W-1:0]   sh_q
);
    typedef struct packed {
        logic [REG_W-1:0] sh;
    } sh_state_t;

    sh_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_SHIFT: st_d.sh = {st_q.sh[REG_W-2:0], sdi};
            OP_WRITE: begin
                for (int k = 0; k < NUM_OUT; k++) begin
                    if (hit[k]) begin
                        st_d.sh[k*SLOT_W +: SLOT_W] =
                            {pdata[SEL_W], 1'b1, pdata[SEL_W-1:0]};
                    end
                end
            end
            default: ;
        endcase
    end

    // No reset: the staging image must survive rst_n.
    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sh_q = st_q.sh;
endmodule

// File: rtl/xbar_cfg_rank2.sv
module xbar_cfg_rank2
    import xbar_cfg_pkg::*;
#(
    parameter int NUM_OUT = 8,
    parameter int SEL_W   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  cfg_op_e                  op,
    input  logic [NUM_OUT-1:0]       cfg_en,
    input  logic [NUM_OUT*SEL_W-1:0] cfg_sel,
    output logic [NUM_OUT-1:0]       out_en,
    output logic [NUM_OUT*SEL_W-1:0] out_sel
);
    typedef struct packed {
        logic [NUM_OUT-1:0]       en;
        logic [NUM_OUT*SEL_W-1:0] sel;
    } rank_t;

    rank_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (op == OP_UPDATE) begin
            r_d.en  = cfg_en;
            r_d.sel = cfg_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign out_en  = r_q.en;
    assign out_sel = r_q.sel;
endmodule

// File: rtl/xbar_cfg_ctrl.sv
module xbar_cfg_ctrl
    import xbar_cfg_pkg::*;
#(
    parameter int NUM_OUT = 8,
    parameter int SEL_W   = 3,
    parameter int ADDR_W  = $clog2(NUM_OUT)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ce_n,
    input  logic                     par_sel,
    input  logic                     upd_n,
    input  logic                     sdi,
    input  logic [SEL_W:0]           pdata,
    input  logic [ADDR_W-1:0]        paddr,
    output logic                     sdo,
    output logic [NUM_OUT-1:0]       out_en,
    output logic [NUM_OUT*SEL_W-1:0] out_sel
);
    localparam int SLOT_W = SEL_W + 2;
    localparam int REG_W  = NUM_OUT * SLOT_W;

    cfg_op_e                  op;
    logic [NUM_OUT-1:0]       hit;
    logic [REG_W-1:0]         sh_q;
    logic [NUM_OUT-1:0]       cfg_en;
    logic [NUM_OUT*SEL_W-1:0] cfg_sel;

    assign op = op_decode(ce_n, par_sel, upd_n);

    xbar_slot_dec #(.NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W)) u_dec (
        .addr (paddr),
        .en   (op == OP_WRITE),
        .hit  (hit)
    );

    xbar_cfg_shreg #(.NUM_OUT(NUM_OUT), .SEL_W(SEL_W)) u_shreg (
        .clk   (clk),
        .op    (op),
        .sdi   (sdi),
        .pdata (pdata),
        .hit   (hit),
        .sh_q  (sh_q)
    );

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_field
        assign cfg_en[k]                 = sh_q[k*SLOT_W + SEL_W + 1];
        assign cfg_sel[k*SEL_W +: SEL_W] = sh_q[k*SLOT_W +: SEL_W];
    end

    xbar_cfg_rank2 #(.NUM_OUT(NUM_OUT), .SEL_W(SEL_W)) u_rank2 (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .cfg_en  (cfg_en),
        .cfg_sel (cfg_sel),
        .out_en  (out_en),
        .out_sel (out_sel)
    );

    assign sdo = sh_q[REG_W-1];
endmodule

// File: rtl/xbar_cfg_chk.sv
module xbar_cfg_chk #(
    parameter int NUM_OUT = 8,
    parameter int SEL_W   = 3,
    parameter int ADDR_W  = $clog2(NUM_OUT),
    parameter int SLOT_W  = SEL_W + 2,
    parameter int REG_W   = NUM_OUT * SLOT_W
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     ce_n,
    input logic                     par_sel,
    input logic                     upd_n,
    input logic                     sdi,
    input logic [SEL_W:0]           pdata,
    input logic [ADDR_W-1:0]        paddr,
    input logic [REG_W-1:0]         sh_q,
    input logic [NUM_OUT-1:0]       out_en,
    input logic [NUM_OUT*SEL_W-1:0] out_sel
);
    a_r2_stage_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> $stable(sh_q));

    a_r2_outputs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> ($stable(out_en) && $stable(out_sel)));

    a_r3_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && upd_n && !par_sel) |=>
        (sh_q[0] == $past(sdi) && sh_q[REG_W-1:1] == $past(sh_q[REG_W-2:0])));

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_slot
        a_r4_slot_write: assert property (@(posedge clk) disable iff (!rst_n)
            (!ce_n && upd_n && par_sel && paddr == ADDR_W'(k)) |=>
            (sh_q[k*SLOT_W +: SLOT_W] ==
             {$past(pdata[SEL_W]), 1'b1, $past(pdata[SEL_W-1:0])}));

        a_r4_slot_untouched: assert property (@(posedge clk) disable iff (!rst_n)
            (!ce_n && upd_n && par_sel && paddr != ADDR_W'(k)) |=>
            $stable(sh_q[k*SLOT_W +: SLOT_W]));

        a_r6_copy_slot: assert property (@(posedge clk) disable iff (!rst_n)
            (!ce_n && !upd_n) |=>
            (out_en[k] == sh_q[k*SLOT_W + SEL_W + 1] &&
             out_sel[k*SEL_W +: SEL_W] == sh_q[k*SLOT_W +: SEL_W]));
    end

    a_r6_no_move_on_update: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !upd_n) |=> $stable(sh_q));

    a_r6_hold_rank: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || upd_n) |=> ($stable(out_en) && $stable(out_sel)));

    a_r7_reset_clear: assert property (@(posedge clk)
        !rst_n |-> (out_en == '0 && out_sel == '0));
endmodule

bind xbar_cfg_ctrl xbar_cfg_chk #(
    .NUM_OUT (NUM_OUT),
    .SEL_W   (SEL_W),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .par_sel (par_sel),
    .upd_n   (upd_n),
    .sdi     (sdi),
    .pdata   (pdata),
    .paddr   (paddr),
    .sh_q    (sh_q),
    .out_en  (out_en),
    .out_sel (out_sel)
);

// File: tb/tb_xbar_cfg_ctrl.sv
`timescale 1ns/1ps
module tb_xbar_cfg_ctrl;
    logic        clk = 1'b0;
    logic        rst_n, ce_n, par_sel, upd_n, sdi;
    logic [3:0]  pdata;
    logic [2:0]  paddr;
    logic        sdo;
    logic [7:0]  out_en;
    logic [23:0] out_sel;

    int n_chk = 0;
    int n_bad = 0;

    // Reference model built from the requirements
    logic [39:0] m_sh;
    logic [7:0]  m_en;
    logic [23:0] m_sel;

    always #4 clk = ~clk;   // 125 MHz

    xbar_cfg_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .par_sel(par_sel),
        .upd_n(upd_n), .sdi(sdi), .pdata(pdata), .paddr(paddr),
        .sdo(sdo), .out_en(out_en), .out_sel(out_sel)
    );

    task automatic check(input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_outputs(input string req);
        check(req, {56'd0, out_en}, {56'd0, m_en});
        check(req, {40'd0, out_sel}, {40'd0, m_sel});
    endtask

    // One clock edge with the given inputs; called just after a negedge.
    task automatic edge_op(input logic ce, input logic ps, input logic up,
                           input logic sd, input logic [3:0] pd,
                           input logic [2:0] pa);
        ce_n = ce; par_sel = ps; upd_n = up; sdi = sd; pdata = pd; paddr = pa;
        @(negedge clk);
        if (!ce) begin
            if (!up) begin
                for (int k = 0; k < 8; k++) begin
                    m_en[k]         = m_sh[5*k+4];
                    m_sel[3*k +: 3] = m_sh[5*k +: 3];
                end
            end else if (!ps) begin
                m_sh = {m_sh[38:0], sd};
            end else begin
                m_sh[5*pa +: 5] = {pd[3], 1'b1, pd[2:0]};
            end
        end
        ce_n = 1'b1;
    endtask

    task automatic do_update();
        edge_op(1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 3'd0);
    endtask

    task automatic t_reset_state();
        check("R7 reset state", {56'd0, out_en}, 64'd0);
        check("R7 reset state", {40'd0, out_sel}, 64'd0);
    endtask

    task automatic t_serial_load(input logic [39:0] img);
        for (int i = 39; i >= 0; i--) edge_op(1'b0, 1'b0, 1'b1, img[i], 4'h0, 3'd0);
        check("R3 serial image", {24'd0, m_sh}, {24'd0, img});
        check("R5 sdo msb serial", {63'd0, sdo}, {63'd0, img[39]});
        do_update();
        check_outputs("R1 R3 R6 serial update");
        check("R6 no shift on update", {63'd0, sdo}, {63'd0, img[39]});
    endtask

    task automatic t_serial_latency();
        logic [39:0] old = m_sh;
        for (int i = 0; i < 40; i++) begin
            edge_op(1'b0, 1'b0, 1'b1, (i == 0), 4'h0, 3'd0);
            if (i < 39) check("R3 latency old bits", {63'd0, sdo}, {63'd0, old[38-i]});
        end
        check("R3 first bit after 40 edges", {63'd0, sdo}, 64'd1);
    endtask

    task automatic t_parallel();
        logic [7:0]  en0  = out_en;
        logic [23:0] sel0 = out_sel;
        edge_op(1'b0, 1'b1, 1'b1, 1'b0, 4'hD, 3'd0);
        edge_op(1'b0, 1'b1, 1'b1, 1'b0, 4'h6, 3'd3);
        edge_op(1'b0, 1'b1, 1'b1, 1'b0, 4'hA, 3'd7);
        check("R5 sdo msb parallel", {63'd0, sdo}, 64'd1);
        edge_op(1'b0, 1'b1, 1'b1, 1'b0, 4'h2, 3'd7);
        check("R5 sdo msb parallel", {63'd0, sdo}, 64'd0);
        check("R6 hold without update", {56'd0, out_en}, {56'd0, en0});
        check("R6 hold without update", {40'd0, out_sel}, {40'd0, sel0});
        do_update();
        check_outputs("R1 R4 parallel update");
        check("R4 slot0 sel", {61'd0, out_sel[2:0]}, 64'd5);
        check("R4 slot3 enable", {63'd0, out_en[3]}, 64'd0);
    endtask

    task automatic t_ce_hold();
        logic [7:0]  en0  = out_en;
        logic [23:0] sel0 = out_sel;
        logic        so0  = sdo;
        for (int i = 0; i < 6; i++)
            edge_op(1'b1, i[0], i[1], 1'b1, 4'hF, 3'(i));
        check("R2 sdo frozen", {63'd0, sdo}, {63'd0, so0});
        check("R2 outputs frozen", {56'd0, out_en}, {56'd0, en0});
        check("R2 outputs frozen", {40'd0, out_sel}, {40'd0, sel0});
        do_update();
        check_outputs("R2 staging untouched");
    endtask

    task automatic t_reserved();
        for (int k = 0; k < 8; k++)
            edge_op(1'b0, 1'b1, 1'b1, 1'b0, 4'(k * 3), 3'(k));
        for (int i = 0; i < 40; i++) begin
            check("R8 R5 readback bit", {63'd0, sdo}, {63'd0, m_sh[39]});
            if (i % 5 == 1) check("R8 reserved bit is 1", {63'd0, sdo}, 64'd1);
            edge_op(1'b0, 1'b0, 1'b1, 1'b1, 4'h0, 3'd0);
        end
        do_update();
        check_outputs("R8 after readback");
    endtask

    task automatic t_async_reset();
        t_serial_load(40'hF7_BDEF_7BDE);
        #2 rst_n = 1'b0;
        #1;
        m_en = '0; m_sel = '0;
        check_outputs("R7 async clear");
        @(negedge clk);
        check_outputs("R7 held in reset");
        rst_n = 1'b1;
        do_update();
        check_outputs("R7 staging kept");
        check("R7 staging kept en", {56'd0, out_en}, 64'hFF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ce_n = 1'b1; par_sel = 1'b0; upd_n = 1'b1;
        sdi = 1'b0; pdata = '0; paddr = '0;
        m_sh = '0; m_en = '0; m_sel = '0;
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        // Fill staging with a known image before relying on the model.
        t_serial_load(40'hA5_3C96_E1F0);
        t_serial_load(40'h12_F0E4_8BD7);
        t_serial_latency();
        t_parallel();
        t_ce_hold();
        t_reserved();
        t_async_reset();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule